// File: doc/BRIEF.md
# Packed Halfword Add/Subtract Unit

This unit executes signed packed 16-bit arithmetic on 32-bit registers. Each 32-bit register holds two halfword lanes. The unit processes the two lanes independently. Two of its four operations exchange the halves of the second operand before combining them. It contains a 16 x 32 register file. A valid instruction word reads two sources from that file and writes the packed result back at the same clock edge. The following cycle reports whether the instruction was performed or rejected.

A debug port gives outside access to the register file. It reads any register combinationally, and it can load a register with a value so that operands can be seeded. Instructions outside the unit's group are ignored completely. Instructions inside the group that carry an unknown operation code are rejected and flagged.

Top module: `pk16_addsub`

## Requirements
- R1: While rst_ni is low, all 16 registers read as zero through the debug port, and done_o, wrote_o and unsup_o are low.
- R2: An instruction with valid_i high is handled only when bits [27:20] equal 0x61. Any other value in that field writes no register and raises no flag on the next cycle.
- R3: Operation code 0xF1 in bits [11:4] gives low = Rn.lo + Rm.lo and high = Rn.hi + Rm.hi. Rd is bits [15:12], Rn is bits [19:16] and Rm is bits [3:0].
- R4: Operation code 0xF7 gives low = Rn.lo - Rm.lo and high = Rn.hi - Rm.hi.
- R5: Operation code 0xF3 gives low = Rn.lo - Rm.hi and high = Rn.hi + Rm.lo.
- R6: Operation code 0xF5 gives low = Rn.lo + Rm.hi and high = Rn.hi - Rm.lo.
- R7: Each lane wraps modulo 2^16 with no saturation, and no carry or borrow passes between lanes. The high lane is result bits [31:16] and the low lane is bits [15:0].
- R8: A handled instruction whose bits [11:4] hold any other code writes no register. On the next cycle it raises done_o and unsup_o, with wrote_o low.
- R9: A supported instruction writes Rd at the clock edge where it is presented. On the next cycle done_o and wrote_o are high for exactly one cycle, unless another instruction follows.
- R10: When Rd equals Rn and/or Rm, the operands are the values from before the write.
- R11: dbg_data_o shows register dbg_idx_i combinationally. When dbg_we_i is high, dbg_wdata_i is written into that register at the clock edge. If both write ports target the same register at the same edge, the instruction result wins.
- R12: With valid_i low, the instruction word has no effect on registers or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 32 | Instruction word |
| dbg_idx_i | input | 4 | Debug register index |
| dbg_we_i | input | 1 | Debug write enable |
| dbg_wdata_i | input | 32 | Debug write data |
| dbg_data_o | output | 32 | Debug read data (combinational) |
| done_o | output | 1 | Handled instruction completed last cycle |
| wrote_o | output | 1 | Last handled instruction wrote Rd |
| unsup_o | output | 1 | Last handled instruction was unsupported |

## Verification
The instruction result lands in Rd at the rising edge where valid_i is sampled. Because the debug read path is combinational, the destination is read back at the falling edge that follows. The done, wrote and unsup flags are registered, so they are due at that same falling edge, one edge after the instruction. The bench drives inputs on falling edges and samples flags and register contents one half cycle after the relevant rising edge. It checks that done_o has dropped one cycle later. Expected values come from a shadow register array updated by the bench's own lane model.

// File: rtl/pk16_pkg.sv
package pk16_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 4;
  localparam int unsigned NREGS     = 1 << REG_IDX_W;
  localparam int unsigned LANE_W    = 16;
  localparam int unsigned LANES     = 2;
  localparam int unsigned DATA_W    = LANE_W * LANES;

  localparam logic [7:0] GROUP_CODE = 8'h61;
  localparam logic [7:0] CODE_ADD   = 8'hF1;
  localparam logic [7:0] CODE_SUB   = 8'hF7;
  localparam logic [7:0] CODE_ASX   = 8'hF3;
  localparam logic [7:0] CODE_SAX   = 8'hF5;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_ASX = 2'd2,  // lo: a.lo - b.hi, hi: a.hi + b.lo
    OP_SAX = 2'd3   // lo: a.lo + b.hi, hi: a.hi - b.lo
  } op_e;

  typedef struct packed {
    logic                 handled;
    logic                 supported;
    op_e                  op;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rn;
    logic [REG_IDX_W-1:0] rm;
  } dec_t;
endpackage

// File: rtl/pk16_decode.sv
module pk16_decode
  import pk16_pkg::*;
(
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  logic [3:0] unused_cond;
  assign unused_cond = instr_i[31:28];

  always_comb begin
    dec_o           = '0;
    dec_o.rn        = instr_i[19:16];
    dec_o.rd        = instr_i[15:12];
    dec_o.rm        = instr_i[3:0];
    dec_o.handled   = valid_i && (instr_i[27:20] == GROUP_CODE);
    dec_o.supported = 1'b1;
    dec_o.op        = OP_ADD;
    unique case (instr_i[11:4])
      CODE_ADD: dec_o.op = OP_ADD;
      CODE_SUB: dec_o.op = OP_SUB;
      CODE_ASX: dec_o.op = OP_ASX;
      CODE_SAX: dec_o.op = OP_SAX;
      default:  dec_o.supported = 1'b0;
    endcase
  end
endmodule

// File: rtl/pk16_lanes.sv
module pk16_lanes
  import pk16_pkg::*;
#(
  parameter int unsigned LW = LANE_W,
  localparam int unsigned DW = LW * LANES
) (
  input  op_e           op_i,
  input  logic [DW-1:0] rn_i,
  input  logic [DW-1:0] rm_i,
  output logic [DW-1:0] res_o
);
  logic exch;
  assign exch = (op_i == OP_ASX) || (op_i == OP_SAX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned OTHER = LANES - 1 - g;
    logic [LW-1:0] a, b;
    logic          sub;
    assign a   = rn_i[g*LW +: LW];
    assign b   = exch ? rm_i[OTHER*LW +: LW] : rm_i[g*LW +: LW];
    // exchange forms subtract in one lane and add in the other
    assign sub = (op_i == OP_SUB)
               || ((op_i == OP_ASX) && (g == 0))
               || ((op_i == OP_SAX) && (g == 1));
    assign res_o[g*LW +: LW] = sub ? (a - b) : (a + b);
  end
endmodule

// File: rtl/pk16_regfile.sv
module pk16_regfile #(
  parameter int unsigned DW = 32,
  parameter int unsigned NR = 16,
  localparam int unsigned IW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_o,
  input  logic [IW-1:0] dbg_idx_i,
  output logic [DW-1:0] dbg_o,
  input  logic          dbg_we_i,
  input  logic [DW-1:0] dbg_wdata_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i
);
  logic [NR-1:0][DW-1:0] mem_q;

  assign ra_o  = mem_q[ra_idx_i];
  assign rb_o  = mem_q[rb_idx_i];
  assign dbg_o = mem_q[dbg_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
    end else begin
      if (dbg_we_i) mem_q[dbg_idx_i] <= dbg_wdata_i;
      if (we_i)     mem_q[waddr_i]   <= wdata_i;  // instruction wins
    end
  end

  // R9
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));

  for (genvar k = 0; k < NR; k++) begin : g_hold
    // R2 R8 R12: entries not addressed by a write keep their value
    entry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(we_i && waddr_i == k) && !(dbg_we_i && dbg_idx_i == k)) |=> $stable(mem_q[k]));
  end
endmodule

// File: rtl/pk16_addsub.sv
module pk16_addsub
  import pk16_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [REG_IDX_W-1:0] dbg_idx_i,
  input  logic                 dbg_we_i,
  input  logic [DATA_W-1:0]    dbg_wdata_i,
  output logic [DATA_W-1:0]    dbg_data_o,
  output logic                 done_o,
  output logic                 wrote_o,
  output logic                 unsup_o
);
  dec_t              dec;
  logic [DATA_W-1:0] rn_val, rm_val, res;
  logic              we;

  pk16_decode i_decode (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  pk16_regfile #(.DW(DATA_W), .NR(NREGS)) i_regfile (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ra_idx_i    (dec.rn),
    .ra_o        (rn_val),
    .rb_idx_i    (dec.rm),
    .rb_o        (rm_val),
    .dbg_idx_i   (dbg_idx_i),
    .dbg_o       (dbg_data_o),
    .dbg_we_i    (dbg_we_i),
    .dbg_wdata_i (dbg_wdata_i),
    .we_i        (we),
    .waddr_i     (dec.rd),
    .wdata_i     (res)
  );

  pk16_lanes #(.LW(LANE_W)) i_lanes (
    .op_i  (dec.op),
    .rn_i  (rn_val),
    .rm_i  (rm_val),
    .res_o (res)
  );

  assign we = dec.handled && dec.supported;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      wrote_o <= 1'b0;
      unsup_o <= 1'b0;
    end else begin
      done_o  <= dec.handled;
      wrote_o <= we;
      unsup_o <= dec.handled && !dec.supported;
    end
  end

  // R9 R8
  flags_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || wrote_o || unsup_o) |-> (done_o && $countones({wrote_o, unsup_o}) == 1));

  // R2
  done_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i && instr_i[27:20] == GROUP_CODE));

  // R12
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
endmodule

// File: tb/test_pk16_addsub.sv
module test_pk16_addsub;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [31:0] instr_i;
  logic [3:0]  dbg_idx_i;
  logic        dbg_we_i;
  logic [31:0] dbg_wdata_i;
  logic [31:0] dbg_data_o;
  logic        done_o, wrote_o, unsup_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  pk16_addsub i_pk16_addsub (.*);

  logic [31:0] model_q [16];
  int checks = 0;
  int errors = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] calc(logic [7:0] code, logic [31:0] a, logic [31:0] b);
    logic [15:0] lo, hi;
    case (code)
      8'hF1:   begin lo = a[15:0] + b[15:0];  hi = a[31:16] + b[31:16]; end
      8'hF7:   begin lo = a[15:0] - b[15:0];  hi = a[31:16] - b[31:16]; end
      8'hF3:   begin lo = a[15:0] - b[31:16]; hi = a[31:16] + b[15:0];  end
      default: begin lo = a[15:0] + b[31:16]; hi = a[31:16] - b[15:0];  end
    endcase
    return {hi, lo};
  endfunction

  function automatic logic [31:0] mk(logic [7:0] grp, logic [7:0] code,
                                     logic [3:0] rd, logic [3:0] rn, logic [3:0] rm);
    return {4'hE, grp, rn, rd, code, rm};
  endfunction

  function automatic string tag_of(logic [7:0] code);
    case (code)
      8'hF1:   return "R3";
      8'hF7:   return "R4";
      8'hF3:   return "R5";
      8'hF5:   return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic seed(logic [3:0] idx, logic [31:0] val);
    @(negedge clk_i);
    dbg_we_i = 1'b1; dbg_idx_i = idx; dbg_wdata_i = val;
    @(negedge clk_i);
    dbg_we_i = 1'b0;
    model_q[idx] = val;
  endtask

  task automatic exec(logic v, logic [31:0] ins, string req);
    logic        hnd, sup;
    logic [31:0] exp;
    logic [3:0]  rd;
    rd  = ins[15:12];
    hnd = v && ins[27:20] == 8'h61;
    sup = hnd && (ins[11:4] inside {8'hF1, 8'hF7, 8'hF3, 8'hF5});
    exp = calc(ins[11:4], model_q[ins[19:16]], model_q[ins[3:0]]);
    @(negedge clk_i);
    valid_i = v; instr_i = ins;
    @(negedge clk_i);
    valid_i = 1'b0; instr_i = $urandom;
    chk(req, "done_o",  {31'd0, done_o},  {31'd0, hnd});
    chk(req, "wrote_o", {31'd0, wrote_o}, {31'd0, sup});
    chk(req, "unsup_o", {31'd0, unsup_o}, {31'd0, hnd && !sup});
    if (sup) model_q[rd] = exp;
    dbg_idx_i = rd;
    #1;
    chk(req, "Rd", dbg_data_o, model_q[rd]);
  endtask

  task automatic scan(string req);
    for (int k = 0; k < 16; k++) begin
      dbg_idx_i = 4'(k);
      #1;
      chk(req, "reg scan", dbg_data_o, model_q[k]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] codes [5];
    logic [31:0] dummy;
    dummy = $urandom(32'h5EED_0C1A);
    codes[0] = 8'hF1; codes[1] = 8'hF7; codes[2] = 8'hF3; codes[3] = 8'hF5; codes[4] = 8'h00;
    rst_ni = 1'b0; valid_i = 1'b0; instr_i = '0;
    dbg_idx_i = '0; dbg_we_i = 1'b0; dbg_wdata_i = '0;
    for (int k = 0; k < 16; k++) model_q[k] = '0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1", "flags", {29'd0, done_o, wrote_o, unsup_o}, 32'd0);
    scan("R1");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R11 debug write/read
    seed(4'd1, 32'h7FFF_8000);
    seed(4'd2, 32'h0001_FFFF);
    seed(4'd3, 32'h1234_5678);
    seed(4'd4, 32'hFFFF_0001);
    scan("R11");

    // R3 R7 wrap without cross-lane carry: lo 8000+FFFF, hi 7FFF+0001
    exec(1'b1, mk(8'h61, 8'hF1, 4'd5, 4'd1, 4'd2), "R3");
    chk("R7", "lane wrap", model_q[5], 32'h8000_7FFF);
    exec(1'b1, mk(8'h61, 8'hF7, 4'd6, 4'd2, 4'd1), "R4");
    exec(1'b1, mk(8'h61, 8'hF3, 4'd7, 4'd3, 4'd4), "R5");
    exec(1'b1, mk(8'h61, 8'hF5, 4'd8, 4'd3, 4'd4), "R6");
    // R8 unsupported code
    exec(1'b1, mk(8'h61, 8'hF9, 4'd1, 4'd2, 4'd3), "R8");
    // R2 other group
    exec(1'b1, mk(8'h62, 8'hF1, 4'd1, 4'd2, 4'd3), "R2");
    // R12 valid low
    exec(1'b0, mk(8'h61, 8'hF1, 4'd1, 4'd2, 4'd3), "R12");
    // R10 in place
    exec(1'b1, mk(8'h61, 8'hF3, 4'd3, 4'd3, 4'd3), "R10");
    exec(1'b1, mk(8'h61, 8'hF7, 4'd4, 4'd1, 4'd4), "R10");
    // R9 pulse drops one cycle later
    @(negedge clk_i);
    chk("R9", "done drop", {31'd0, done_o}, 32'd0);
    // R11 collision: instruction result wins over debug write
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = mk(8'h61, 8'hF1, 4'd9, 4'd1, 4'd2);
    dbg_we_i = 1'b1; dbg_idx_i = 4'd9; dbg_wdata_i = 32'hDEAD_BEEF;
    model_q[9] = calc(8'hF1, model_q[1], model_q[2]);
    @(negedge clk_i);
    valid_i = 1'b0; dbg_we_i = 1'b0;
    #1;
    chk("R11", "collision", dbg_data_o, model_q[9]);

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] grp, code;
      if (($urandom % 8) == 0) seed(4'($urandom), $urandom);
      grp  = (($urandom % 8) == 0) ? 8'($urandom) : 8'h61;
      code = codes[$urandom % 5];
      if (code == 8'h00) code = 8'($urandom);
      exec(($urandom % 16) != 0,
           mk(grp, code, 4'($urandom), 4'($urandom), 4'($urandom)), tag_of(code));
    end
    scan("R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule